// File: doc/BRIEF.md
# PLL clock mode controller

This block is the control model that sits around an analog PLL and decides which clock drives the core. It watches three clock inputs: the reference, the multiplied PLL output and a free-running limp oscillator. It samples them with a fast system clock and produces a registered core clock, `clk_out`. At reset, a strap pin picks one of two behaviours. With the strap low, the PLL is bypassed completely. With the strap high, a 4-bit multiplier register chooses between a divide-by-two of the reference and a divide-by-two of the PLL output. The register's value is also driven out to the analog PLL, which places the reference times that value on `pll_clk`.

Every accepted write to the multiplier register restarts a settling wait that counts reference edges, and the PLL path is selected only after the wait completes. While the multiplier is nonzero, a monitor counts limp-clock edges between reference edges. If the reference goes silent, the monitor raises a failure flag that stays set until reset and moves the core clock onto the limp oscillator permanently. A watchdog down-counter advances on reference edges only, so it freezes when the reference is lost. While the watchdog is enabled, writes to the multiplier register are refused. The output source changes only while `clk_out` is low.

Top module: `pll_clk_mode_ctrl`

## Requirements
- R1: With `pll_dis_n` low during reset, `mode` is 0 (disabled) and stays 0 until the next reset. `clk_out` follows the reference level with no division. Multiplier writes, including writes that hold a value of 0, do not change `mode`.
- R2: With `pll_dis_n` high during reset and a multiplier of 0, `mode` is 1 (bypass) and `clk_out` toggles on each reference rising edge, which gives the reference divided by two.
- R3: After a nonzero multiplier n is accepted and lock is reached, `mode` becomes 2 (enabled), `ratio` reads n, and `clk_out` toggles on each `pll_clk` rising edge.
- R4: An accepted write drops `lock` in the next cycle. `lock` rises again after LOCK_CYCLES reference rising edges (default 131072). Until then, `mode` stays 1.
- R5: A write that repeats the current multiplier value still restarts the full settling wait.
- R6: A write made while `wd_en` is high leaves `ratio` and `lock` unchanged and sets the sticky flag `wr_err`.
- R7: With the strap high and a nonzero multiplier, if MISS_LIMIT (default 16) limp rising edges pass with no reference rising edge, `clk_fail` is set, `mode` becomes 3 (limp), and `clk_out` follows the limp clock level.
- R8: With a multiplier of 0, a missing reference sets neither `clk_fail` nor limp mode.
- R9: `clk_fail` and limp mode hold until reset, even after the reference returns.
- R10: `wd_count` decrements by one on each reference rising edge while `wd_en` is high. It holds while `wd_en` is low or while the reference is missing.
- R11: `mode` changes only in a cycle that follows a cycle in which `clk_out` was low.
- R12: In reset, `lock` is 1, `clk_fail`, `wr_err`, `ratio` and `clk_out` are 0, and `wd_count` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk | input | 1 | Reference clock, sampled |
| limp_clk | input | 1 | Free-running fallback oscillator, sampled |
| pll_clk | input | 1 | Multiplied PLL output, sampled |
| pll_dis_n | input | 1 | Strap, captured during reset; low disables the PLL path |
| wr_en | input | 1 | Multiplier register write strobe |
| wr_ratio | input | 4 | Multiplier write data |
| wd_en | input | 1 | Watchdog enable; also blocks multiplier writes |
| clk_out | output | 1 | Generated core clock |
| mode | output | 2 | Active source: 0 disabled, 1 bypass, 2 enabled, 3 limp |
| ratio | output | 4 | Current multiplier, driven to the analog PLL |
| lock | output | 1 | Settling wait complete |
| clk_fail | output | 1 | Sticky loss-of-reference flag |
| wr_err | output | 1 | Sticky refused-write flag |
| wd_count | output | 16 | Watchdog down-counter |

## Verification
The hardest state to reach is a loss of reference while the PLL path is active. Reaching it takes a reset with the strap high, an accepted nonzero write, and a full settling wait. The bench shortens the wait with a small LOCK_CYCLES override. Its reference generator has a gate that holds the line low, so the reference can be stopped part-way through a run while the limp and PLL generators keep running. A monitor runs for the whole session and compares every change of `mode` with the previous sample of `clk_out`. This covers the source switches that the reset, write and failure scenarios trigger.

// File: rtl/pllc_pkg.sv
package pllc_pkg;
    typedef enum logic [1:0] {
        MODE_DIS  = 2'd0,
        MODE_BYP  = 2'd1,
        MODE_ENA  = 2'd2,
        MODE_LIMP = 2'd3
    } clk_mode_e;

    localparam int unsigned N_SRC   = 3;
    localparam int unsigned SRC_REF  = 0;
    localparam int unsigned SRC_LIMP = 1;
    localparam int unsigned SRC_PLL  = 2;
endpackage

// File: rtl/pllc_sync.sv
module pllc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        if (!rst_n) sh_d = '0;
        else        sh_d = {sh_q[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk) sh_q <= sh_d;

    assign level = sh_q[STAGES-1];
endmodule

// File: rtl/pllc_lock_timer.sv
module pllc_lock_timer #(
    parameter int unsigned LOCK_CYCLES = 131072
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    output logic locked
);
    localparam int unsigned CNT_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [CNT_W-1:0] DONE = CNT_W'(LOCK_CYCLES);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!rst_n)                    cnt_d = DONE;
        else if (restart)              cnt_d = '0;
        else if (tick && cnt_q != DONE) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) cnt_q <= cnt_d;

    assign locked = (cnt_q == DONE);
endmodule

// File: rtl/pllc_ref_monitor.sv
module pllc_ref_monitor #(
    parameter int unsigned MISS_LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic limp_tick,
    output logic missing
);
    localparam int unsigned CNT_W = $clog2(MISS_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MISS_LIMIT);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!rst_n)                           cnt_d = '0;
        else if (ref_tick)                    cnt_d = '0;
        else if (limp_tick && cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) cnt_q <= cnt_d;

    assign missing = (cnt_q == LIMIT);
endmodule

// File: rtl/pll_clk_mode_ctrl.sv
module pll_clk_mode_ctrl
    import pllc_pkg::*;
#(
    parameter int unsigned RATIO_W     = 4,
    parameter int unsigned WD_W        = 16,
    parameter int unsigned LOCK_CYCLES = 131072,
    parameter int unsigned MISS_LIMIT  = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_clk,
    input  logic               limp_clk,
    input  logic               pll_clk,
    input  logic               pll_dis_n,
    input  logic               wr_en,
    input  logic [RATIO_W-1:0] wr_ratio,
    input  logic               wd_en,
    output logic               clk_out,
    output logic [1:0]         mode,
    output logic [RATIO_W-1:0] ratio,
    output logic               lock,
    output logic               clk_fail,
    output logic               wr_err,
    output logic [WD_W-1:0]    wd_count
);
    typedef struct packed {
        logic               dis;
        logic [RATIO_W-1:0] ratio;
        logic               wr_err;
        logic               fail;
        clk_mode_e          sel;
        logic               out;
        logic [WD_W-1:0]    wd;
        logic [N_SRC-1:0]   prev;
    } state_t;

    state_t st_d, st_q;

    logic [N_SRC-1:0] src_raw, lvl, rise;
    logic             accept, locked, missing;
    clk_mode_e        target;
    logic             natural;

    assign src_raw[SRC_REF]  = ref_clk;
    assign src_raw[SRC_LIMP] = limp_clk;
    assign src_raw[SRC_PLL]  = pll_clk;

    for (genvar g = 0; g < N_SRC; g++) begin : g_sync
        pllc_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_in(src_raw[g]),
            .level   (lvl[g])
        );
    end

    assign rise   = lvl & ~st_q.prev;
    assign accept = wr_en && !wd_en;

    pllc_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(accept),
        .tick   (rise[SRC_REF]),
        .locked (locked)
    );

    pllc_ref_monitor #(.MISS_LIMIT(MISS_LIMIT)) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (rise[SRC_REF]),
        .limp_tick(rise[SRC_LIMP]),
        .missing  (missing)
    );

    always_comb begin
        if (st_q.dis)                              target = MODE_DIS;
        else if (st_q.fail)                        target = MODE_LIMP;
        else if (st_q.ratio != '0 && locked)       target = MODE_ENA;
        else                                       target = MODE_BYP;

        unique case (st_q.sel)
            MODE_DIS:  natural = lvl[SRC_REF];
            MODE_BYP:  natural = rise[SRC_REF] ? ~st_q.out : st_q.out;
            MODE_ENA:  natural = rise[SRC_PLL] ? ~st_q.out : st_q.out;
            default:   natural = lvl[SRC_LIMP];
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;

        if (accept) st_d.ratio = wr_ratio;
        if (wr_en && wd_en) st_d.wr_err = 1'b1;

        if (!st_q.dis && st_q.ratio != '0 && missing) st_d.fail = 1'b1;

        if (wd_en && rise[SRC_REF]) st_d.wd = st_q.wd - 1'b1;

        if (target == st_q.sel) begin
            st_d.out = natural;
        end else if (!st_q.out) begin
            st_d.sel = target;
            st_d.out = 1'b0;
        end else begin
            st_d.out = (target == MODE_LIMP) ? 1'b0 : natural;
        end

        if (!rst_n) begin
            st_d        = '0;
            st_d.dis    = ~pll_dis_n;
            st_d.sel    = pll_dis_n ? MODE_BYP : MODE_DIS;
            st_d.wd     = '1;
        end
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign clk_out  = st_q.out;
    assign mode     = st_q.sel;
    assign ratio    = st_q.ratio;
    assign lock     = locked;
    assign clk_fail = st_q.fail;
    assign wr_err   = st_q.wr_err;
    assign wd_count = st_q.wd;
endmodule

// File: rtl/pllc_checker.sv
module pllc_checker #(
    parameter int unsigned RATIO_W = 4,
    parameter int unsigned WD_W    = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic               wd_en,
    input logic               clk_out,
    input logic [1:0]         mode,
    input logic [RATIO_W-1:0] ratio,
    input logic               lock,
    input logic               clk_fail,
    input logic               wr_err,
    input logic [WD_W-1:0]    wd_count
);
    p_dis_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |=> (mode == 2'd0));

    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wd_en) |=> !lock);

    p_block_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wd_en) |=> ($stable(ratio) && wr_err));

    p_fail_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_fail) |-> ($past(ratio) != '0));

    p_fail_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clk_fail |=> clk_fail);

    p_limp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |=> (mode == 2'd3));

    p_wd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_en |=> $stable(wd_count));

    p_mode_at_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode) |-> !$past(clk_out));
endmodule

bind pll_clk_mode_ctrl pllc_checker #(.RATIO_W(RATIO_W), .WD_W(WD_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wd_en   (wd_en),
    .clk_out (clk_out),
    .mode    (mode),
    .ratio   (ratio),
    .lock    (lock),
    .clk_fail(clk_fail),
    .wr_err  (wr_err),
    .wd_count(wd_count)
);

// File: tb/pll_clk_mode_ctrl_test.sv
module pll_clk_mode_ctrl_test;
    localparam int LOCK_N = 40;

    logic        clk = 0, rst_n = 0;
    logic        ref_clk = 0, limp_clk = 0, pll_clk = 0;
    logic        pll_dis_n = 1, wr_en = 0, wd_en = 0;
    logic [3:0]  wr_ratio = 0;
    logic        clk_out, lock, clk_fail, wr_err;
    logic [1:0]  mode;
    logic [3:0]  ratio;
    logic [15:0] wd_count;
    logic        ref_on = 1;

    int n_chk = 0, n_bad = 0, bound_bad = 0;
    logic [1:0] mode_prev = 0;
    logic       out_prev = 0;

    pll_clk_mode_ctrl #(.LOCK_CYCLES(LOCK_N)) uut (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .limp_clk(limp_clk),
        .pll_clk(pll_clk), .pll_dis_n(pll_dis_n), .wr_en(wr_en),
        .wr_ratio(wr_ratio), .wd_en(wd_en), .clk_out(clk_out), .mode(mode),
        .ratio(ratio), .lock(lock), .clk_fail(clk_fail), .wr_err(wr_err),
        .wd_count(wd_count)
    );

    always #10 clk = ~clk;

    initial forever begin #80;  ref_clk  = ref_on ? ~ref_clk : 1'b0; end
    initial forever begin #100; limp_clk = ~limp_clk; end
    initial forever begin #60;  pll_clk  = ~pll_clk; end

    always @(negedge clk) begin
        if (rst_n && mode != mode_prev && out_prev) bound_bad++;
        mode_prev = mode;
        out_prev  = clk_out;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_near(input string req, input int act, input int exp, input int tol);
        n_chk++;
        if (act < exp - tol || act > exp + tol) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic count_rises(input int n, output int r);
        logic p;
        r = 0;
        p = clk_out;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (clk_out && !p) r++;
            p = clk_out;
        end
    endtask

    task automatic write_ratio(input logic [3:0] v);
        wr_ratio = v;
        wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    // R12: reset state, strap captured during reset
    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 0;
        pll_dis_n = strap;
        cycles(4);
        check("R12 lock", lock, 1);
        check("R12 clk_fail", clk_fail, 0);
        check("R12 wr_err", wr_err, 0);
        check("R12 ratio", ratio, 0);
        check("R12 clk_out", clk_out, 0);
        check("R12 wd_count", wd_count, 16'hffff);
        rst_n = 1;
        cycles(2);
    endtask

    task automatic t_bypass;
        int r;
        do_reset(1);
        check("R2 mode", mode, 1);
        count_rises(480, r);
        check_near("R2 ref/2 rate", r, 30, 2);
    endtask

    task automatic t_enable;
        int r;
        write_ratio(4'd5);
        check("R4 lock drop", lock, 0);
        cycles(300);
        check("R4 lock still low", lock, 0);
        check("R4 mode held bypass", mode, 1);
        cycles(44);
        check("R4 lock after wait", lock, 1);
        cycles(20);
        check("R3 mode", mode, 2);
        check("R3 ratio", ratio, 5);
        count_rises(480, r);
        check_near("R3 pll/2 rate", r, 40, 2);
    endtask

    task automatic t_same_value;
        write_ratio(4'd5);
        cycles(240);
        check("R5 lock low 1st", lock, 0);
        write_ratio(4'd5);
        cycles(240);
        check("R5 lock low after repeat", lock, 0);
        cycles(120);
        check("R5 lock after repeat", lock, 1);
        cycles(20);
    endtask

    task automatic t_wd_block;
        int w0;
        wd_en = 1;
        @(negedge clk);
        write_ratio(4'd9);
        check("R6 ratio kept", ratio, 5);
        check("R6 wr_err", wr_err, 1);
        check("R6 lock kept", lock, 1);
        w0 = wd_count;
        cycles(160);
        check_near("R10 wd decrements", w0 - int'(wd_count), 20, 1);
        wd_en = 0;
        @(negedge clk);
        w0 = wd_count;
        cycles(80);
        check("R10 wd hold disabled", wd_count, w0);
    endtask

    task automatic t_fail;
        int r, w0;
        ref_on = 0;
        cycles(260);
        check("R7 clk_fail", clk_fail, 1);
        cycles(20);
        check("R7 mode limp", mode, 3);
        count_rises(480, r);
        check_near("R7 limp rate", r, 48, 2);
        wd_en = 1;
        cycles(4);
        w0 = wd_count;
        cycles(200);
        check("R10 wd frozen", wd_count, w0);
        wd_en = 0;
        ref_on = 1;
        cycles(400);
        check("R9 fail sticky", clk_fail, 1);
        check("R9 stays limp", mode, 3);
    endtask

    task automatic t_no_fail_bypass;
        do_reset(1);
        ref_on = 0;
        cycles(400);
        check("R8 no fail", clk_fail, 0);
        check("R8 still bypass", mode, 1);
        ref_on = 1;
        cycles(40);
    endtask

    task automatic t_disabled;
        int r;
        do_reset(0);
        check("R1 mode", mode, 0);
        count_rises(480, r);
        check_near("R1 passthrough rate", r, 60, 2);
        write_ratio(4'd3);
        cycles(600);
        check("R1 mode after write", mode, 0);
        write_ratio(4'd0);
        cycles(40);
        check("R1 mode after zero write", mode, 0);
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_bypass();
        t_enable();
        t_same_value();
        t_wd_block();
        t_fail();
        t_no_fail_bypass();
        t_disabled();
        check("R11 switch only when low", bound_bad, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule